// File: doc/BRIEF.md
# Floating-Point Slot Queue with Head-Only Execution

This block sits between the single-issue front end and a floating-point execution unit. Floating-point operations enter a four-entry in-order queue whenever at least one entry is free. Only the oldest entry, the head, executes. The head stays busy for a number of cycles set by its operation class, then retires with a one-cycle pulse that carries its tag. The entry behind it then takes over the head in the next cycle. Transfers between floating-point and general registers, and floating-point compares, use only the issue slot. They never enter the queue and leave its state untouched. The arithmetic itself is outside this block.

The head is controlled by a two-state machine. `HS_IDLE` means no entry is executing. `HS_RUN` means the head entry is executing, with a down-counter holding the cycles it has left. The four transitions are:
- `T_START` (HS_IDLE to HS_RUN): an operation is accepted into an empty queue.
- `T_HOLD` (HS_RUN to HS_RUN): the head is not finished and the counter decrements.
- `T_CHAIN` (HS_RUN to HS_RUN): the head retires and a successor exists, so the counter reloads with the successor's latency.
- `T_DRAIN` (HS_RUN to HS_IDLE): the head retires and nothing follows it.

An enqueue offered while the queue is full is accepted only if the head retires in that same cycle. In that case the freed entry is reused at once.

Top module: `fp_slot_queue`

## Requirements
- R1: After reset, `full`, `exec_valid` and `retire_valid` are all 0.
- R2: An enqueue with a queued class (codes 0 to 3) is accepted whenever fewer than four entries are resident. `full` is 1 exactly when four entries are resident. An enqueue offered while full, in a cycle with no retire, is dropped, and its tag never executes.
- R3: When the queue is full and `retire_valid` is 1, an enqueue in that cycle is accepted, and `full` is still 1 in the next cycle.
- R4: An operation accepted into an empty queue shows `exec_valid`=1 with its tag on `exec_tag` in the cycle after acceptance.
- R5: The head stays executing for a latency set by its class, counted from the first cycle it executes. The class codes and latencies are:
  - code 0 (register move or float-to-integer conversion): 1 cycle;
  - code 1 (integer-to-float conversion): 2 cycles;
  - code 2 (general arithmetic): 3 cycles;
  - code 3 (divide or square root): 30 cycles.
  `retire_valid` is 1 in the last of those cycles.
- R6: When the head retires and another entry is resident, or one is accepted in that cycle, that entry executes in the next cycle.
- R7: `retire_tag` equals the tag of the entry that is retiring, and tags retire in the order they were accepted.
- R8: Class codes 4 to 7 (transfers between register files, and compares) are never queued. They have no effect on `full`, `exec_valid`, `exec_tag` or `retire_valid`.
- R9: Only the head executes. While it is executing and not retiring, `exec_tag` holds steady in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An operation is offered this cycle |
| enq_class | input | 3 | Operation class (codes 0 to 3 are queued, 4 to 7 bypass the queue) |
| enq_tag | input | TAG_W | Tag of the offered operation |
| full | output | 1 | All four entries are occupied |
| exec_valid | output | 1 | The head entry is executing |
| exec_tag | output | TAG_W | Tag of the executing head entry |
| retire_valid | output | 1 | The head completes in this cycle |
| retire_tag | output | TAG_W | Tag of the completing entry |

## Verification
Each class is first offered alone into an empty queue, with idle gaps between offers. This isolates the start delay and the per-class occupancy, so a wrong latency constant or a missing start cycle cannot hide behind a busy queue. A back-to-back stream of long divides then fills the queue and keeps offering. This separates a correct drop-when-full from an overwrite, and a continuous stream of arithmetic tests that a retire while full frees its entry for an enqueue in the same cycle. Bypass codes are driven both into an idle queue and into a busy one, which shows they alter no state. A long random mix of all eight codes is compared cycle by cycle against a behavioural queue model, and it exposes ordering and chaining faults that the directed patterns miss.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    typedef enum logic [2:0] {
        OPC_MOVE  = 3'd0,
        OPC_ITOF  = 3'd1,
        OPC_ARITH = 3'd2,
        OPC_DIVSQ = 3'd3,
        OPC_XFER  = 3'd4,
        OPC_CMP   = 3'd5,
        OPC_RSV6  = 3'd6,
        OPC_RSV7  = 3'd7
    } opclass_t;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_RUN  = 1'b1
    } head_state_t;

    function automatic logic is_queued(input opclass_t c);
        return (c[2] == 1'b0);
    endfunction

endpackage

// File: rtl/fpq_lat_decode.sv
module fpq_lat_decode
    import fpq_pkg::*;
#(
    parameter int LAT_MOVE  = 1,
    parameter int LAT_ITOF  = 2,
    parameter int LAT_ARITH = 3,
    parameter int LAT_DIVSQ = 30,
    parameter int LAT_W     = 5
) (
    input  opclass_t         cls,
    output logic [LAT_W-1:0] lat
);

    always_comb begin
        unique case (cls)
            OPC_MOVE:  lat = LAT_W'(LAT_MOVE);
            OPC_ITOF:  lat = LAT_W'(LAT_ITOF);
            OPC_ARITH: lat = LAT_W'(LAT_ARITH);
            OPC_DIVSQ: lat = LAT_W'(LAT_DIVSQ);
            default:   lat = LAT_W'(1);
        endcase
    end

endmodule

// File: rtl/fpq_ring.sv
module fpq_ring
    import fpq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 6,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [TAG_W-1:0] push_tag,
    input  opclass_t         push_cls,
    output logic [TAG_W-1:0] head_tag,
    output opclass_t         next_cls,
    output logic [CNT_W-1:0] occ
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_nxt;
    logic [TAG_W-1:0] slot_tag [DEPTH];
    opclass_t         slot_cls [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign rd_nxt = wrap_inc(rd_ptr);

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && (wr_ptr == PTR_W'(s))) begin
                    slot_tag[s] <= push_tag;
                    slot_cls[s] <= push_cls;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wrap_inc(wr_ptr);
            if (pop)  rd_ptr <= rd_nxt;
            occ <= occ + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_tag = slot_tag[rd_ptr];
    assign next_cls = slot_cls[rd_nxt];

endmodule

// File: rtl/fpq_head_fsm.sv
module fpq_head_fsm
    import fpq_pkg::*;
#(
    parameter int LAT_W = 5,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CNT_W-1:0] occ,
    input  logic [LAT_W-1:0] enq_lat,
    input  logic [LAT_W-1:0] next_lat,
    output logic             running,
    output logic             retire
);

    head_state_t      state, state_nx;
    logic [LAT_W-1:0] rem, rem_nx;
    logic             last_cycle;
    logic             has_succ;

    assign last_cycle = (state == HS_RUN) && (rem == LAT_W'(1));
    assign has_succ   = (occ > CNT_W'(1)) || push;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            rem   <= '0;
        end else begin
            state <= state_nx;
            rem   <= rem_nx;
        end
    end

    // transitions: T_START, T_HOLD, T_CHAIN, T_DRAIN
    always_comb begin
        state_nx = state;
        rem_nx   = rem;
        unique case (state)
            HS_IDLE: begin
                if (push) begin                 // T_START
                    state_nx = HS_RUN;
                    rem_nx   = enq_lat;
                end
            end
            HS_RUN: begin
                if (!last_cycle) begin          // T_HOLD
                    rem_nx = rem - LAT_W'(1);
                end else if (has_succ) begin    // T_CHAIN
                    rem_nx = (occ > CNT_W'(1)) ? next_lat : enq_lat;
                end else begin                  // T_DRAIN
                    state_nx = HS_IDLE;
                    rem_nx   = '0;
                end
            end
            default: state_nx = HS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = (state == HS_RUN);
        retire  = last_cycle;
    end

endmodule

// File: rtl/fp_slot_queue.sv
module fp_slot_queue
    import fpq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 6,
    parameter int LAT_MOVE  = 1,
    parameter int LAT_ITOF  = 2,
    parameter int LAT_ARITH = 3,
    parameter int LAT_DIVSQ = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [2:0]       enq_class,
    input  logic [TAG_W-1:0] enq_tag,
    output logic             full,
    output logic             exec_valid,
    output logic [TAG_W-1:0] exec_tag,
    output logic             retire_valid,
    output logic [TAG_W-1:0] retire_tag
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LAT_W = $clog2(LAT_DIVSQ + 1);

    opclass_t         in_cls;
    opclass_t         next_cls;
    logic             accept;
    logic             retire_i;
    logic             running;
    logic [CNT_W-1:0] occ;
    logic [LAT_W-1:0] enq_lat;
    logic [LAT_W-1:0] next_lat;
    logic [TAG_W-1:0] head_tag;

    assign in_cls = opclass_t'(enq_class);
    assign full   = (occ == CNT_W'(DEPTH));
    assign accept = enq_valid && is_queued(in_cls) && (!full || retire_i);

    fpq_ring #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .pop(retire_i),
        .push_tag(enq_tag), .push_cls(in_cls),
        .head_tag(head_tag), .next_cls(next_cls), .occ(occ)
    );

    fpq_lat_decode #(
        .LAT_MOVE(LAT_MOVE), .LAT_ITOF(LAT_ITOF), .LAT_ARITH(LAT_ARITH),
        .LAT_DIVSQ(LAT_DIVSQ), .LAT_W(LAT_W)
    ) u_lat_in (
        .cls(in_cls), .lat(enq_lat)
    );

    fpq_lat_decode #(
        .LAT_MOVE(LAT_MOVE), .LAT_ITOF(LAT_ITOF), .LAT_ARITH(LAT_ARITH),
        .LAT_DIVSQ(LAT_DIVSQ), .LAT_W(LAT_W)
    ) u_lat_nx (
        .cls(next_cls), .lat(next_lat)
    );

    fpq_head_fsm #(
        .LAT_W(LAT_W), .CNT_W(CNT_W)
    ) u_head (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .occ(occ),
        .enq_lat(enq_lat), .next_lat(next_lat),
        .running(running), .retire(retire_i)
    );

    assign exec_valid   = running;
    assign exec_tag     = head_tag;
    assign retire_valid = retire_i;
    assign retire_tag   = head_tag;

endmodule

// File: rtl/fpq_checker.sv
module fpq_checker #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 6,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic [2:0]       enq_class,
    input logic [TAG_W-1:0] enq_tag,
    input logic             full,
    input logic             exec_valid,
    input logic [TAG_W-1:0] exec_tag,
    input logic             retire_valid,
    input logic [TAG_W-1:0] retire_tag,
    input logic [CNT_W-1:0] occ,
    input logic             accept
);

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full && !retire_valid |-> !accept);

    p_full_reuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid && !enq_class[2] && full && retire_valid |=> full);

    p_start_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid && accept |=> exec_valid && (exec_tag == $past(enq_tag)));

    p_retire_in_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> exec_valid);

    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid && (occ > CNT_W'(1)) |=> exec_valid);

    p_retire_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> retire_tag == exec_tag);

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid && enq_class[2] && !retire_valid |=> $stable(occ));

    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && !retire_valid |=> exec_valid && $stable(exec_tag));

endmodule

bind fp_slot_queue fpq_checker #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_class(enq_class), .enq_tag(enq_tag),
    .full(full), .exec_valid(exec_valid), .exec_tag(exec_tag),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .occ(occ), .accept(accept)
);

// File: tb/fp_slot_queue_tb.sv
module fp_slot_queue_tb;

    localparam int TAG_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq_valid = 1'b0;
    logic [2:0]       enq_class = 3'd0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic             full;
    logic             exec_valid;
    logic [TAG_W-1:0] exec_tag;
    logic             retire_valid;
    logic [TAG_W-1:0] retire_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [TAG_W-1:0] mq_tag[$];
    int               mq_cls[$];
    bit               m_run = 0;
    int               m_rem = 0;
    logic [TAG_W-1:0] tag_ctr = '0;
    string            phase = "R1";
    bit               seen_ret;
    bit               seen_full;

    always #4 clk = ~clk;

    fp_slot_queue #(.TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_class(enq_class), .enq_tag(enq_tag),
        .full(full), .exec_valid(exec_valid), .exec_tag(exec_tag),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    function automatic int lat_of(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 30;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s (phase %s): got %0d expected %0d",
                     req, what, phase, got, exp);
        end
    endtask

    task automatic compare_all();
        bit m_full, m_ret;
        m_full = (mq_tag.size() == 4);
        m_ret  = m_run && (m_rem == 1);
        chk(full == m_full, "R2", "full", int'(full), int'(m_full));
        chk(exec_valid == m_run, "R6", "exec_valid", int'(exec_valid), int'(m_run));
        chk(retire_valid == m_ret, "R5", "retire_valid", int'(retire_valid), int'(m_ret));
        if (m_run)
            chk(exec_tag == mq_tag[0], "R9", "exec_tag", int'(exec_tag), int'(mq_tag[0]));
        if (m_ret)
            chk(retire_tag == mq_tag[0], "R7", "retire_tag", int'(retire_tag), int'(mq_tag[0]));
        seen_ret  = retire_valid;
        seen_full = full;
    endtask

    task automatic model_step(input bit v, input int c, input logic [TAG_W-1:0] t);
        bit ret, acc;
        ret = m_run && (m_rem == 1);
        acc = v && (c < 4) && ((mq_tag.size() < 4) || ret);
        if (ret) begin
            void'(mq_tag.pop_front());
            void'(mq_cls.pop_front());
        end
        if (acc) begin
            mq_tag.push_back(t);
            mq_cls.push_back(c);
        end
        if (m_run && !ret) m_rem--;
        else if (mq_tag.size() > 0) begin
            m_run = 1;
            m_rem = lat_of(mq_cls[0]);
        end else m_run = 0;
    endtask

    task automatic cyc(input bit v, input int c);
        @(negedge clk);
        compare_all();
        enq_valid = v;
        enq_class = 3'(c);
        enq_tag   = tag_ctr;
        model_step(v, c, tag_ctr);
        if (v) tag_ctr++;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(full == 0, "R1", "full", int'(full), 0);
        chk(exec_valid == 0, "R1", "exec_valid", int'(exec_valid), 0);
        chk(retire_valid == 0, "R1", "retire_valid", int'(retire_valid), 0);

        // R4 and R5: each class alone into an empty queue
        phase = "R5";
        for (int c = 0; c < 4; c++) begin
            cyc(1, c);
            n = 0;
            for (int i = 1; i <= 40; i++) begin
                cyc(0, 0);
                if (i == 1)
                    chk(exec_valid == 1, "R4", "exec_valid after accept", int'(exec_valid), 1);
                if (seen_ret && n == 0) n = i;
            end
            chk(n == lat_of(c), "R5", "occupancy cycles", n, lat_of(c));
        end

        // R8: bypass codes into an idle queue
        phase = "R8";
        for (int c = 4; c < 8; c++) cyc(1, c);
        cyc(0, 0);
        chk(exec_valid == 0 && full == 0, "R8", "idle after bypass",
            int'(exec_valid) + int'(full), 0);

        // R2: fill with divides, keep offering (dropped)
        phase = "R2";
        for (int i = 0; i < 8; i++) cyc(1, 3);
        cyc(0, 0);
        chk(full == 1, "R2", "full after fill", int'(full), 1);
        // R8 while busy
        phase = "R8";
        for (int i = 0; i < 10; i++) cyc(1, 4 + (i % 4));
        phase = "R2";
        repeat (130) cyc(0, 0);

        // R3: continuous arithmetic stream keeps the queue full
        phase = "R3";
        for (int i = 0; i < 40; i++) begin
            cyc(1, 2);
            if (seen_full && seen_ret) begin
                cyc(1, 2);
                chk(seen_full == 1, "R3", "full after retire with enqueue",
                    int'(seen_full), 1);
            end
        end
        repeat (20) cyc(0, 0);

        // R6, R7, R9: random mix
        phase = "R7";
        for (int i = 0; i < 3000; i++) begin
            int r, c;
            r = $urandom_range(0, 99);
            c = $urandom_range(0, 99);
            if (c < 30) c = 0;
            else if (c < 50) c = 1;
            else if (c < 75) c = 2;
            else if (c < 82) c = 3;
            else c = $urandom_range(4, 7);
            cyc(r < 60, c);
        end
        repeat (200) cyc(0, 0);
        chk(mq_tag.size() == 0 && exec_valid == 0, "R6", "drained",
            int'(exec_valid), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule